// File: doc/BRIEF.md
# GPIO Port with Level-Sensitive Interrupt Controller

This block is a memory-mapped general-purpose I/O port of up to 32 pins, with the number of implemented pins set by a parameter. Software decides per pin whether it drives out or samples in. It writes output values and reads back either the driven value or the synchronized input level. Each pin can raise an interrupt while its synchronized level equals a polarity that software chooses per pin. Edge sensing does not exist.

Every pin has a sticky status bit. Software acknowledges one pin by writing the complement of that pin's bit to the status register, so a 0 clears and a 1 preserves. A second register window shows the status bits as pending interrupts and holds a per-pin mask. The unmasked pending bits are OR-ed into a single host interrupt line. The register bus is a plain synchronous port: a write strobe is taken at the clock edge, and read data follows the address combinationally.

Top module: `gpio_lvlirq`

## Requirements
- R1: After reset the direction, output data, polarity and status registers all read 0, the mask register reads all implemented bits as 1, and `irq` is low.
- R2: A direction bit of 1 makes the pin an output. `pin_oe` for that pin is high, `pin_out` carries the output-data bit, and a read of the data register (offset 0x04) returns the output-data bit for that pin.
- R3: For a pin whose direction bit is 0, a read of the data register returns the pin level after a two-flop synchronizer. A change on `pin_in` is not visible after one clock edge and is visible after two.
- R4: A polarity bit of 1 (offset 0x08) makes the pin active-high. Its status bit is set on the clock edge after the synchronized level is 1.
- R5: A polarity bit of 0 makes the pin active-low. An input driven low shows in the status register (offset 0x0C) three clock edges after the change on `pin_in`.
- R6: A write to the status register clears each bit written as 0 and leaves each bit written as 1 unchanged. Without such a write a set status bit stays set after its level goes inactive.
- R7: Writing 0 to a status bit while its pin is still at the active level leaves the bit reading 1.
- R8: The pending register (offset 0x10) reads the current status bits whatever the mask holds. Writes to it have no effect.
- R9: The mask register is at offset 0x18, and a mask bit of 1 blocks its pin. `irq` is high exactly when some status bit is set whose mask bit is 0.
- R10: Register bits at and above the implemented pin count (default 12) read as 0 and ignore writes. The pin outputs and output enables of those bits stay 0.
- R11: Address bit 4 selects the interrupt window and bits 3:2 select the register. An address with bit 1 or bit 0 set, or an unused offset in the interrupt window (0x14, 0x1C), reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register byte address; bit 4 selects the interrupt window |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables, 1 = drive |
| irq | output | 1 | Combined host interrupt, active high |

## Verification
The embedded properties assume that `reg_wr` and `reg_wdata` hold steady across the sampling edge. They also assume that reset is held for at least one edge before any register traffic. The bench drives every write and every pin change just after a falling edge and makes each write strobe exactly one cycle wide. `pin_in` is treated as asynchronous by the design. The bench still changes it only on falling edges, so the two-edge synchronizer delay can be counted exactly. Pin levels are returned to their inactive state before a status bit is cleared, except in the one case that checks that a clear does not take while the level is still active.

// File: rtl/gpio_lvlirq_pkg.sv
package gpio_lvlirq_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;

    // Register index, taken from address bits 3:2
    typedef enum logic [1:0] {
        RG_DIR  = 2'd0,
        RG_DATA = 2'd1,
        RG_POL  = 2'd2,
        RG_STAT = 2'd3
    } gpio_reg_e;

    typedef enum logic [1:0] {
        RI_PEND = 2'd0,
        RI_GAP0 = 2'd1,
        RI_MASK = 2'd2,
        RI_GAP1 = 2'd3
    } irq_reg_e;

    typedef struct packed {
        logic dir;
        logic data;
        logic pol;
        logic stat;
        logic mask;
    } wr_strobe_t;

    typedef struct packed {
        logic      irq_win;
        logic [1:0] idx;
        logic      aligned;
    } addr_dec_t;

    function automatic logic [WORD_W-1:0] pin_mask(input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic addr_dec_t split_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d.irq_win = a[4];
        d.idx     = a[3:2];
        d.aligned = (a[1:0] == 2'b00);
        return d;
    endfunction

    function automatic wr_strobe_t decode_wr(input addr_dec_t d, input logic we);
        wr_strobe_t s;
        s = '0;
        if (we && d.aligned) begin
            if (!d.irq_win) begin
                unique case (gpio_reg_e'(d.idx))
                    RG_DIR:  s.dir  = 1'b1;
                    RG_DATA: s.data = 1'b1;
                    RG_POL:  s.pol  = 1'b1;
                    RG_STAT: s.stat = 1'b1;
                endcase
            end else if (irq_reg_e'(d.idx) == RI_MASK) begin
                s.mask = 1'b1;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_lvlirq_pkg::*;
#(
    parameter int NPINS = 12,
    parameter logic RST_LVL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] raw_i,
    output logic [WORD_W-1:0] lvl_o
);
    localparam logic [WORD_W-1:0] PMASK = pin_mask(NPINS);

    logic [WORD_W-1:0] stage1;
    logic [WORD_W-1:0] stage2;

    for (genvar g = 0; g < WORD_W; g++) begin : g_bit
        if (g < NPINS) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage1[g] <= RST_LVL;
                    stage2[g] <= RST_LVL;
                end else begin
                    stage1[g] <= raw_i[g];
                    stage2[g] <= stage1[g];
                end
            end
        end else begin : g_tie
            assign stage1[g] = 1'b0;
            assign stage2[g] = 1'b0;
        end
    end

    assign lvl_o = stage2 & PMASK;

    // R3: the synchronized level lags the raw pin by exactly two edges
    a_r3_two_stage: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (lvl_o == ($past(raw_i, 2) & PMASK)));

endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_lvlirq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] lvl_i,
    output logic [WORD_W-1:0] dir_o,
    output logic [WORD_W-1:0] dout_o,
    output logic [WORD_W-1:0] pol_o,
    output logic [WORD_W-1:0] data_view_o
);
    localparam logic [WORD_W-1:0] PMASK = pin_mask(NPINS);

    logic [WORD_W-1:0] dir_q, dout_q, pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            dout_q <= '0;
            pol_q  <= '0;
        end else begin
            if (wr_i.dir)  dir_q  <= wdata_i & PMASK;
            if (wr_i.data) dout_q <= wdata_i & PMASK;
            if (wr_i.pol)  pol_q  <= wdata_i & PMASK;
        end
    end

    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            data_view_o[i] = dir_q[i] ? dout_q[i] : lvl_i[i];
        end
    end

    assign dir_o  = dir_q;
    assign dout_o = dout_q;
    assign pol_o  = pol_q;

    // R2: a direction write lands in the enable register on the next edge
    a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_i.dir)) |-> (dir_o == ($past(wdata_i) & PMASK)));

    // R10: unimplemented bits never appear on the drive side
    a_r10_upper_quiet: assert property (@(posedge clk) disable iff (rst)
        ((dir_o | dout_o | pol_o) & ~PMASK) == '0);

endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat
    import gpio_lvlirq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] lvl_i,
    input  logic [WORD_W-1:0] pol_i,
    output logic [WORD_W-1:0] stat_o,
    output logic [WORD_W-1:0] mask_o,
    output logic              irq_o
);
    localparam logic [WORD_W-1:0] PMASK = pin_mask(NPINS);

    logic [WORD_W-1:0] stat_q, mask_q, hit, keep, enabled;

    // A pin is active while its level equals its polarity bit
    assign hit  = ~(lvl_i ^ pol_i) & PMASK;
    assign keep = wr_i.stat ? wdata_i : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= PMASK;
        end else begin
            stat_q <= ((stat_q & keep) | hit) & PMASK;
            if (wr_i.mask) mask_q <= wdata_i & PMASK;
        end
    end

    assign enabled = stat_q & ~mask_q;
    assign irq_o   = |enabled;
    assign stat_o  = stat_q;
    assign mask_o  = mask_q;

    // R1: reset leaves every line masked and nothing latched
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_o == PMASK && stat_o == '0 && !irq_o));

    // R4: an active level latches on the next edge
    a_r4_latch_active: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat_o & $past(hit)) == $past(hit)));

    // R6: without a status write no latched bit is lost
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_i.stat)) |-> ((stat_o & $past(stat_o)) == $past(stat_o)));

    // R9: the host line needs at least one latched bit
    a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (stat_o != '0));

endmodule

// File: rtl/gpio_lvlirq.sv
module gpio_lvlirq
    import gpio_lvlirq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [WORD_W-1:0] pin_in,
    output logic [WORD_W-1:0] pin_out,
    output logic [WORD_W-1:0] pin_oe,
    output logic              irq
);
    addr_dec_t         dec;
    wr_strobe_t        wr;
    logic [WORD_W-1:0] lvl, dir, dout, pol, view, stat, mask;

    assign dec = split_addr(reg_addr);
    assign wr  = decode_wr(dec, reg_wr);

    gpio_sync #(.NPINS(NPINS), .RST_LVL(1'b1)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (pin_in),
        .lvl_o (lvl)
    );

    gpio_pin_regs #(.NPINS(NPINS)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (wr),
        .wdata_i     (reg_wdata),
        .lvl_i       (lvl),
        .dir_o       (dir),
        .dout_o      (dout),
        .pol_o       (pol),
        .data_view_o (view)
    );

    gpio_irq_stat #(.NPINS(NPINS)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .wdata_i (reg_wdata),
        .lvl_i   (lvl),
        .pol_i   (pol),
        .stat_o  (stat),
        .mask_o  (mask),
        .irq_o   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (dec.aligned) begin
            if (!dec.irq_win) begin
                unique case (gpio_reg_e'(dec.idx))
                    RG_DIR:  reg_rdata = dir;
                    RG_DATA: reg_rdata = view;
                    RG_POL:  reg_rdata = pol;
                    RG_STAT: reg_rdata = stat;
                endcase
            end else begin
                unique case (irq_reg_e'(dec.idx))
                    RI_PEND: reg_rdata = stat;
                    RI_MASK: reg_rdata = mask;
                    default: reg_rdata = '0;
                endcase
            end
        end
    end

    assign pin_out = dout;
    assign pin_oe  = dir;

    // R11: a misaligned address never returns data
    a_r11_misaligned: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0));

endmodule

// File: tb/gpio_lvlirq_test.sv
module gpio_lvlirq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = 32'hFFFF_FFFF;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int outstanding = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 register read, 1 irq, 2 pin_out, 3 pin_oe
        logic [4:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;

    gpio_lvlirq #(.NPINS(12)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Monitor: pops one expectation per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() != 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                if (it.kind == 0) reg_addr = it.addr;
                #2;
                case (it.kind)
                    0:       got = reg_rdata;
                    1:       got = {31'd0, irq};
                    2:       got = pin_out;
                    default: got = pin_oe;
                endcase
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: kind %0d addr %h actual %h expected %h",
                             it.req, it.kind, it.addr, got, it.exp);
                end
                outstanding--;
            end
        end
    end

    task automatic expect_item(input int kind, input logic [4:0] a,
                               input logic [31:0] e, input string r);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.req = r;
        outstanding++;
        q.push_back(it);
        wait (outstanding == 0);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string r);
        @(negedge clk); #1;
        expect_item(0, a, e, r);
    endtask

    task automatic chk(input int kind, input logic [31:0] e, input string r);
        @(negedge clk); #1;
        expect_item(kind, 5'd0, e, r);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h00, 32'h0,   "R1 dir");
        rd(5'h04, 32'hFFF, "R1 data view of high inputs");
        rd(5'h08, 32'h0,   "R1 pol");
        rd(5'h0C, 32'h0,   "R1 status");
        rd(5'h18, 32'hFFF, "R1 mask");
        chk(1, 32'h0,      "R1 irq");

        // R10 upper bits ignored, R2 output path
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, 32'hFFF, "R10 dir upper bits");
        chk(3, 32'hFFF,    "R10 pin_oe upper bits");
        wr(5'h04, 32'hA5A5_A5A5);
        chk(2, 32'h5A5,    "R2 pin_out");
        rd(5'h04, 32'h5A5, "R2 data readback outputs");

        // R3 synchronizer delay with mixed directions
        wr(5'h00, 32'h0F0);
        @(negedge clk);
        pin_in = 32'h0000_000F;
        #1;
        expect_item(0, 5'h04, 32'hFAF, "R3 one edge old level");
        expect_item(0, 5'h04, 32'h0AF, "R3 two edges new level");
        @(negedge clk);
        pin_in = 32'hFFFF_FFFF;
        wr(5'h00, 32'h0);
        wait_edges(4);
        wr(5'h0C, 32'h0);
        rd(5'h0C, 32'h0, "R6 clear all");

        // R5 active-low on pins 3 and 9
        @(negedge clk);
        pin_in = 32'hFFFF_FDF7;
        wait_edges(3);
        rd(5'h0C, 32'h208, "R5 status active-low");
        rd(5'h10, 32'h208, "R8 pending with all masked");
        chk(1, 32'h0,      "R9 masked lines give no irq");

        wr(5'h18, 32'hFFFF_FFF7);
        rd(5'h18, 32'hFF7, "R9 mask readback");
        chk(1, 32'h1,      "R9 unmasked pending raises irq");
        rd(5'h10, 32'h208, "R8 pending ignores mask");

        // R7 clear while active
        wr(5'h0C, 32'hFFFF_FFF7);
        rd(5'h0C, 32'h208, "R7 clear during active level");

        // R6 sticky and selective clear
        @(negedge clk);
        pin_in = 32'hFFFF_FFFF;
        wait_edges(4);
        rd(5'h0C, 32'h208, "R6 sticky after level release");
        wr(5'h0C, 32'hFFFF_FFF7);
        rd(5'h0C, 32'h200, "R6 ones preserve other bit");
        chk(1, 32'h0,      "R9 remaining bit is masked");
        wr(5'h0C, 32'hFFFF_FDFF);
        rd(5'h0C, 32'h0,   "R6 second clear");

        // R4 active-high on pin 4 (input is high)
        wr(5'h08, 32'hFFFF_0010);
        rd(5'h08, 32'h010, "R4 pol readback upper ignored");
        rd(5'h0C, 32'h010, "R4 active-high latch");
        @(negedge clk);
        pin_in = 32'hFFFF_FFEF;
        wait_edges(4);
        wr(5'h0C, 32'hFFFF_FFEF);
        rd(5'h0C, 32'h0,   "R4 cleared after level drops");

        // R11 decode corners and R8 pending write ignored
        wr(5'h10, 32'hFFF);
        rd(5'h10, 32'h0,   "R8 pending write ignored");
        wr(5'h1C, 32'h0);
        rd(5'h18, 32'hFF7, "R11 gap write leaves mask");
        rd(5'h14, 32'h0,   "R11 gap offset reads zero");
        rd(5'h1C, 32'h0,   "R11 gap offset reads zero");
        wr(5'h19, 32'h0);
        rd(5'h18, 32'hFF7, "R11 misaligned write ignored");
        rd(5'h1A, 32'h0,   "R11 misaligned read zero");

        done = 1'b1;
        summary();
    end

endmodule